// File: doc/BRIEF.md
# Linear CCD Line Readout Timing Generator

This block generates the complete set of digital drive clocks for a three-colour linear CCD sensor, one line at a time. A line opens with a single transfer-gate pulse shared by all colours, framed on both sides by a settle gap. Next comes a readout burst in which two complementary shift clocks, their last-stage copies, a per-pixel reset-gate pulse and a clamp clock move the charge out one pixel slot at a time. While the burst runs, the block marks every pixel slot with its class: invalid, optical black, valid or trailing dummy. It also emits a sample strobe for the downstream ADC at a programmable delay after each reset pulse.

All timing is counted in system-clock ticks. The transfer-pulse width, the settle gap, the pixel-slot length, the reset and clamp widths, the sample delay, the number of trailing dummy pixel pairs (which stretches the integration time) and the clamp mode come in as configuration inputs. The block captures them only at the start of each line, so a line is never built from a mix of old and new settings. In bit-clamp mode the clamp clock pulses once per pixel, right after the reset pulse. In line-clamp mode it is the inverse of the transfer pulse.

Top module: `ccd_line_timer`

## Requirements
- R1: After reset and while `run` is low the outputs rest at idle: `tg_o`=0, `rg_o`=1, `clb_o`=1, `sh1_o`=`sh1l_o`=1, `sh2_o`=`sh2l_o`=0, `adc_stb_o`=0, and all four class flags are 0.
- R2: Once a line starts, `tg_o` stays low for `gap_ticks` ticks, then is high for exactly `tg_ticks` ticks, then is low for `gap_ticks` ticks, and then the readout begins.
- R3: Outside readout the shift clocks hold `sh1`=1 and `sh2`=0. During readout `sh1` is high in slots with an even pixel index (counting from 0) and low in slots with an odd index, and it changes only at slot boundaries. `sh2` is always the complement of `sh1`. The last-stage outputs equal `sh1`/`sh2`.
- R4: `rg_o` is high outside readout. During readout it is high for the first `rst_ticks` ticks of each pixel slot and low for the rest of the slot.
- R5: With `clamp_mode`=0 (bit clamp), `clb_o` is high outside readout. During readout it is high for `clb_ticks` ticks, starting in the tick where `rg_o` falls, and low for the rest of the slot.
- R6: With `clamp_mode`=1 (line clamp), `clb_o` is the inverse of `tg_o` at all times.
- R7: During readout exactly one class flag is high. Pixel indices 0..INV-1 and INV+OB..2·INV+OB-1 are invalid, INV..INV+OB-1 are optical black, the next VALID indices are valid, and all later indices are dummy. Outside readout no flag is high.
- R8: A readout lasts 2·INV+OB+VALID+2·`extra_pairs` slots of `pix_ticks` ticks each. In the tick after the last slot, a new line starts (the R2 gap) if `run` is high; otherwise the block returns to idle.
- R9: `adc_stb_o` is a one-tick pulse in every pixel slot, at tick `rst_ticks`+`smp_ticks` of the slot, counting from 0.
- R10: Configuration inputs are captured when a line starts. Changes made during a line take effect from the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Keep generating lines while high |
| clamp_mode | input | 1 | 0 = clamp once per pixel, 1 = clamp per line |
| tg_ticks | input | TW | Transfer pulse width (≥1) |
| gap_ticks | input | TW | Gap on each side of the transfer pulse (≥1) |
| pix_ticks | input | TW | Ticks per pixel slot (≥ rst+clb, > rst+smp) |
| rst_ticks | input | TW | Reset-gate high ticks per slot (≥1) |
| clb_ticks | input | TW | Bit-clamp high ticks per slot |
| smp_ticks | input | TW | Strobe delay after reset falls |
| extra_pairs | input | XW | Trailing dummy pixel pairs per line |
| tg_o | output | 1 | Transfer-gate clock |
| sh1_o | output | 1 | Shift clock phase 1 |
| sh2_o | output | 1 | Shift clock phase 2 |
| sh1l_o | output | 1 | Last-stage shift clock phase 1 |
| sh2l_o | output | 1 | Last-stage shift clock phase 2 |
| rg_o | output | 1 | Reset-gate clock |
| clb_o | output | 1 | Clamp clock |
| adc_stb_o | output | 1 | ADC sample strobe |
| cls_inv_o | output | 1 | Current slot is an invalid pixel |
| cls_ob_o | output | 1 | Current slot is an optical-black pixel |
| cls_valid_o | output | 1 | Current slot is a valid pixel |
| cls_dummy_o | output | 1 | Current slot is a trailing dummy pixel |

## Verification
The bench builds the block with INV_PIX=2, OB_PIX=6, VALID_PIX=12, TW=8 and XW=4. With these values a whole line is a few hundred ticks, so every class boundary, the change from valid to dummy pixels and the wrap into the next line are all checked tick by tick in both clamp modes. The bench also uses several different pixel-slot, reset and strobe settings, and changes the configuration in the middle of a line so that the line-start capture is observed at the outputs.

// File: rtl/ccd_tg_pkg.sv
`timescale 1ns/1ps
// Shared types for the CCD line timing generator.
// Assumes: nothing beyond IEEE 1800-2017.
package ccd_tg_pkg;
    // Phases of one line, in the order they run.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_TG   = 3'd2,
        PH_POST = 3'd3,
        PH_READ = 3'd4
    } phase_e;
endpackage

// File: rtl/ccd_line_seq.sv
`timescale 1ns/1ps
// Line sequencer: walks idle -> pre-gap -> transfer pulse -> post-gap -> readout.
// Assumes: gap_q and tg_q are >= 1 and stay stable for the line (captured by the top).
module ccd_line_seq
    import ccd_tg_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] gap_q,
    input  logic [TW-1:0] tg_q,
    input  logic          line_end,
    output phase_e        phase,
    output logic          load_cfg,
    output logic          tg
);
    logic [TW-1:0] ptick;

    // Request a configuration capture on every line start.
    always_comb load_cfg = run && ((phase == PH_IDLE) || line_end);

    // Transfer-gate clock is simply the transfer phase.
    always_comb tg = (phase == PH_TG);

    // Phase state machine with a per-phase tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            ptick <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    ptick <= '0;
                    if (run) phase <= PH_PRE;
                end
                PH_PRE: begin
                    if (ptick == gap_q - TW'(1)) begin
                        phase <= PH_TG;
                        ptick <= '0;
                    end else ptick <= ptick + TW'(1);
                end
                PH_TG: begin
                    if (ptick == tg_q - TW'(1)) begin
                        phase <= PH_POST;
                        ptick <= '0;
                    end else ptick <= ptick + TW'(1);
                end
                PH_POST: begin
                    if (ptick == gap_q - TW'(1)) begin
                        phase <= PH_READ;
                        ptick <= '0;
                    end else ptick <= ptick + TW'(1);
                end
                PH_READ: begin
                    ptick <= '0;
                    if (line_end) phase <= run ? PH_PRE : PH_IDLE;
                end
                default: begin
                    phase <= PH_IDLE;
                    ptick <= '0;
                end
            endcase
        end
    end

    // R2
    read_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ && $past(phase) != PH_READ) |-> $past(phase) == PH_POST);

    // R8
    line_end_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (phase == PH_PRE || phase == PH_IDLE));
endmodule

// File: rtl/ccd_pix_cnt.sv
`timescale 1ns/1ps
// Pixel counter: counts ticks within a slot and slots within a readout, and classifies each slot.
// Assumes: pix_q >= 1 and stable during readout; VALID is even so pixels pair up.
module ccd_pix_cnt
    import ccd_tg_pkg::*;
#(
    parameter int TW    = 16,
    parameter int XW    = 16,
    parameter int PW    = 18,
    parameter int INV   = 4,
    parameter int OB    = 48,
    parameter int VALID = 21360
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase,
    input  logic [TW-1:0] pix_q,
    input  logic [XW-1:0] extra_q,
    output logic          in_read,
    output logic [TW-1:0] tick,
    output logic          pix_odd,
    output logic          line_end,
    output logic          cls_inv,
    output logic          cls_ob,
    output logic          cls_valid,
    output logic          cls_dummy
);
    localparam int B_OB    = INV;
    localparam int B_INV2  = INV + OB;
    localparam int B_VALID = 2 * INV + OB;
    localparam int B_DUMMY = B_VALID + VALID;

    logic [PW-1:0] k;
    logic [PW-1:0] last_k;
    logic          slot_end;

    // Index of the final slot of this line.
    always_comb last_k = PW'(B_DUMMY) + PW'({extra_q, 1'b0}) - PW'(1);

    // Slot and line completion flags.
    always_comb begin
        in_read  = (phase == PH_READ);
        slot_end = in_read && (tick == pix_q - TW'(1));
        line_end = slot_end && (k == last_k);
        pix_odd  = k[0];
    end

    // Tick and slot counters, cleared whenever not reading out.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_read) begin
            tick <= '0;
            k    <= '0;
        end else if (slot_end) begin
            tick <= '0;
            k    <= (k == last_k) ? '0 : k + PW'(1);
        end else begin
            tick <= tick + TW'(1);
        end
    end

    // Decode the slot index into its pixel class.
    always_comb begin
        cls_inv   = 1'b0;
        cls_ob    = 1'b0;
        cls_valid = 1'b0;
        cls_dummy = 1'b0;
        if (in_read) begin
            if (k < PW'(B_OB))         cls_inv   = 1'b1;
            else if (k < PW'(B_INV2))  cls_ob    = 1'b1;
            else if (k < PW'(B_VALID)) cls_inv   = 1'b1;
            else if (k < PW'(B_DUMMY)) cls_valid = 1'b1;
            else                       cls_dummy = 1'b1;
        end
    end

    // R7
    class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_read |-> $countones({cls_inv, cls_ob, cls_valid, cls_dummy}) == 1);

    // R7
    valid_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cls_valid) |-> $past(cls_inv));
endmodule

// File: rtl/ccd_clk_shaper.sv
`timescale 1ns/1ps
// Clock shaper: forms shift, reset-gate, clamp and strobe waveforms from phase and slot position.
// Assumes: rst_q >= 1, rst_q + clb_q <= pix_q, rst_q + smp_q < pix_q.
module ccd_clk_shaper
    import ccd_tg_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase,
    input  logic          in_read,
    input  logic [TW-1:0] tick,
    input  logic          pix_odd,
    input  logic          mode_q,
    input  logic [TW-1:0] rst_q,
    input  logic [TW-1:0] clb_q,
    input  logic [TW-1:0] smp_q,
    output logic          sh1,
    output logic          sh2,
    output logic          sh1l,
    output logic          sh2l,
    output logic          rg,
    output logic          clb,
    output logic          stb
);
    logic [TW:0] t_x;
    logic [TW:0] clb_end;
    logic [TW:0] stb_at;

    // Widen the slot position and edges by one bit so sums cannot wrap.
    always_comb begin
        t_x     = {1'b0, tick};
        clb_end = {1'b0, rst_q} + {1'b0, clb_q};
        stb_at  = {1'b0, rst_q} + {1'b0, smp_q};
    end

    // Shift clocks: phase 1 high on even slots, held high outside readout.
    always_comb begin
        sh1  = in_read ? ~pix_odd : 1'b1;
        sh2  = ~sh1;
        sh1l = sh1;
        sh2l = sh2;
    end

    // Reset gate at the head of each slot; forced high outside readout.
    always_comb rg = in_read ? (tick < rst_q) : 1'b1;

    // Clamp clock: per-pixel pulse after reset, or the inverse of the transfer gate.
    always_comb begin
        if (mode_q) clb = (phase != PH_TG);
        else        clb = in_read ? ((t_x >= {1'b0, rst_q}) && (t_x < clb_end)) : 1'b1;
    end

    // ADC strobe a fixed delay after the reset pulse falls.
    always_comb stb = in_read && (t_x == stb_at);

    // R3
    sh_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read && $past(in_read) && sh1 != $past(sh1)) |-> tick == '0);

    // R9
    stb_rg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> !rg);

    // R5
    clb_after_rg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && in_read && $rose(clb)) |-> $fell(rg));
endmodule

// File: rtl/ccd_line_timer.sv
`timescale 1ns/1ps
// Top: CCD line readout timing generator. Captures configuration at each line start and
// ties together the line sequencer, the pixel counter and the clock shaper.
// Assumes: configuration values meet the minimums listed on the ports; VALID_PIX is even.
module ccd_line_timer
    import ccd_tg_pkg::*;
#(
    parameter int TW        = 16,
    parameter int XW        = 16,
    parameter int INV_PIX   = 4,
    parameter int OB_PIX    = 48,
    parameter int VALID_PIX = 21360
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clamp_mode,
    input  logic [TW-1:0] tg_ticks,
    input  logic [TW-1:0] gap_ticks,
    input  logic [TW-1:0] pix_ticks,
    input  logic [TW-1:0] rst_ticks,
    input  logic [TW-1:0] clb_ticks,
    input  logic [TW-1:0] smp_ticks,
    input  logic [XW-1:0] extra_pairs,
    output logic          tg_o,
    output logic          sh1_o,
    output logic          sh2_o,
    output logic          sh1l_o,
    output logic          sh2l_o,
    output logic          rg_o,
    output logic          clb_o,
    output logic          adc_stb_o,
    output logic          cls_inv_o,
    output logic          cls_ob_o,
    output logic          cls_valid_o,
    output logic          cls_dummy_o
);
    localparam int LEAD = 2 * INV_PIX + OB_PIX;
    localparam int PW   = $clog2(LEAD + VALID_PIX + 2 * (2 ** XW)) + 1;

    phase_e        phase;
    logic          load_cfg;
    logic          line_end;
    logic          in_read;
    logic [TW-1:0] tick;
    logic          pix_odd;

    logic          mode_q;
    logic [TW-1:0] tg_q, gap_q, pix_q, rst_q, clb_q, smp_q;
    logic [XW-1:0] extra_q;

    // Shadow the configuration so one line always uses one consistent set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            tg_q    <= '0;
            gap_q   <= '0;
            pix_q   <= '0;
            rst_q   <= '0;
            clb_q   <= '0;
            smp_q   <= '0;
            extra_q <= '0;
        end else if (load_cfg) begin
            mode_q  <= clamp_mode;
            tg_q    <= tg_ticks;
            gap_q   <= gap_ticks;
            pix_q   <= pix_ticks;
            rst_q   <= rst_ticks;
            clb_q   <= clb_ticks;
            smp_q   <= smp_ticks;
            extra_q <= extra_pairs;
        end
    end

    ccd_line_seq #(.TW(TW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .gap_q    (gap_q),
        .tg_q     (tg_q),
        .line_end (line_end),
        .phase    (phase),
        .load_cfg (load_cfg),
        .tg       (tg_o)
    );

    ccd_pix_cnt #(
        .TW(TW), .XW(XW), .PW(PW),
        .INV(INV_PIX), .OB(OB_PIX), .VALID(VALID_PIX)
    ) u_pix (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .pix_q     (pix_q),
        .extra_q   (extra_q),
        .in_read   (in_read),
        .tick      (tick),
        .pix_odd   (pix_odd),
        .line_end  (line_end),
        .cls_inv   (cls_inv_o),
        .cls_ob    (cls_ob_o),
        .cls_valid (cls_valid_o),
        .cls_dummy (cls_dummy_o)
    );

    ccd_clk_shaper #(.TW(TW)) u_shape (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .in_read (in_read),
        .tick    (tick),
        .pix_odd (pix_odd),
        .mode_q  (mode_q),
        .rst_q   (rst_q),
        .clb_q   (clb_q),
        .smp_q   (smp_q),
        .sh1     (sh1_o),
        .sh2     (sh2_o),
        .sh1l    (sh1l_o),
        .sh2l    (sh2l_o),
        .rg      (rg_o),
        .clb     (clb_o),
        .stb     (adc_stb_o)
    );
endmodule

// File: tb/tb_ccd_line_timer.sv
`timescale 1ns/1ps
module tb_ccd_line_timer;
    localparam int TW = 8;
    localparam int XW = 4;
    localparam int INV = 2;
    localparam int OB = 6;
    localparam int VALID = 12;

    typedef struct {
        int mode, tg, gap, pix, rst, clb, smp, extra;
    } bcfg_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic clamp_mode = 1'b0;
    logic [TW-1:0] tg_ticks = '0, gap_ticks = '0, pix_ticks = '0;
    logic [TW-1:0] rst_ticks = '0, clb_ticks = '0, smp_ticks = '0;
    logic [XW-1:0] extra_pairs = '0;
    logic tg_o, sh1_o, sh2_o, sh1l_o, sh2l_o, rg_o, clb_o, adc_stb_o;
    logic cls_inv_o, cls_ob_o, cls_valid_o, cls_dummy_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ccd_line_timer #(.TW(TW), .XW(XW), .INV_PIX(INV), .OB_PIX(OB), .VALID_PIX(VALID)) dut (
        .clk(clk), .rst_n(rst_n), .run(run), .clamp_mode(clamp_mode),
        .tg_ticks(tg_ticks), .gap_ticks(gap_ticks), .pix_ticks(pix_ticks),
        .rst_ticks(rst_ticks), .clb_ticks(clb_ticks), .smp_ticks(smp_ticks),
        .extra_pairs(extra_pairs),
        .tg_o(tg_o), .sh1_o(sh1_o), .sh2_o(sh2_o), .sh1l_o(sh1l_o), .sh2l_o(sh2l_o),
        .rg_o(rg_o), .clb_o(clb_o), .adc_stb_o(adc_stb_o),
        .cls_inv_o(cls_inv_o), .cls_ob_o(cls_ob_o), .cls_valid_o(cls_valid_o),
        .cls_dummy_o(cls_dummy_o)
    );

    task automatic chk(input string req, input string nm, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic apply_cfg(input bcfg_t c);
        clamp_mode  = c.mode[0];
        tg_ticks    = TW'(c.tg);
        gap_ticks   = TW'(c.gap);
        pix_ticks   = TW'(c.pix);
        rst_ticks   = TW'(c.rst);
        clb_ticks   = TW'(c.clb);
        smp_ticks   = TW'(c.smp);
        extra_pairs = XW'(c.extra);
    endtask

    // Idle outputs expected by R1 (also the state after a finished line, R8).
    task automatic check_idle(input string req);
        chk(req, "tg", tg_o, 0);
        chk(req, "rg", rg_o, 1);
        chk(req, "clb", clb_o, 1);
        chk(req, "sh1", sh1_o, 1);
        chk(req, "sh2", sh2_o, 0);
        chk(req, "sh1l", sh1l_o, 1);
        chk(req, "sh2l", sh2l_o, 0);
        chk(req, "stb", adc_stb_o, 0);
        chk(req, "flags", {cls_inv_o, cls_ob_o, cls_valid_o, cls_dummy_o}, 0);
    endtask

    // Runs nlines lines: line 0 with a, later lines with b (b is applied mid-line 0 for R10).
    task automatic run_lines(input bcfg_t a, input bcfg_t b, input int nlines, input bit recfg);
        apply_cfg(a);
        run = 1'b1;
        for (int ln = 0; ln < nlines; ln++) begin
            bcfg_t cf;
            int n_pix, len;
            cf = (ln == 0) ? a : b;
            n_pix = 2 * INV + OB + VALID + 2 * cf.extra;
            len = 2 * cf.gap + cf.tg + n_pix * cf.pix;
            for (int c = 0; c < len; c++) begin
                int e_tg, e_rg, e_clb, e_sh1, e_stb, e_flags, k, t;
                bit rd;
                string rq_tg, rq_sh, rq_rg, rq_clb, rq_cls, rq_stb;
                @(negedge clk);
                rd = (c >= 2 * cf.gap + cf.tg);
                e_tg = (c >= cf.gap && c < cf.gap + cf.tg) ? 1 : 0;
                k = 0; t = 0;
                if (rd) begin
                    k = (c - 2 * cf.gap - cf.tg) / cf.pix;
                    t = (c - 2 * cf.gap - cf.tg) % cf.pix;
                end
                e_sh1 = rd ? ((k % 2 == 0) ? 1 : 0) : 1;
                e_rg = rd ? ((t < cf.rst) ? 1 : 0) : 1;
                if (cf.mode == 1) e_clb = e_tg ? 0 : 1;
                else e_clb = rd ? ((t >= cf.rst && t < cf.rst + cf.clb) ? 1 : 0) : 1;
                e_stb = (rd && t == cf.rst + cf.smp) ? 1 : 0;
                if (!rd) e_flags = 0;
                else if (k < INV) e_flags = 8;
                else if (k < INV + OB) e_flags = 4;
                else if (k < 2 * INV + OB) e_flags = 8;
                else if (k < 2 * INV + OB + VALID) e_flags = 2;
                else e_flags = 1;
                rq_tg = (ln > 0 && c == 0) ? "R8" : "R2";
                rq_sh = "R3"; rq_rg = "R4"; rq_cls = "R7"; rq_stb = "R9";
                rq_clb = (cf.mode == 1) ? "R6" : "R5";
                if (recfg && ln > 0) begin
                    rq_tg = "R10"; rq_sh = "R10"; rq_rg = "R10";
                    rq_clb = "R10"; rq_cls = "R10"; rq_stb = "R10";
                end
                chk(rq_tg, "tg", tg_o, e_tg);
                chk(rq_sh, "sh1", sh1_o, e_sh1);
                chk(rq_sh, "sh2", sh2_o, 1 - e_sh1);
                chk(rq_sh, "sh1l", sh1l_o, e_sh1);
                chk(rq_sh, "sh2l", sh2l_o, 1 - e_sh1);
                chk(rq_rg, "rg", rg_o, e_rg);
                chk(rq_clb, "clb", clb_o, e_clb);
                chk(rq_stb, "stb", adc_stb_o, e_stb);
                chk(rq_cls, "flags", {cls_inv_o, cls_ob_o, cls_valid_o, cls_dummy_o}, e_flags);
                if (ln == 0 && c == 1) apply_cfg(b);
                if (ln == nlines - 1 && c == 1) run = 1'b0;
            end
        end
        // R8: after the last slot with run low, the block is idle again.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_idle("R8");
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_idle("R1");
        // R1: stays idle while run is low.
        repeat (5) @(negedge clk);
        check_idle("R1");
    endtask

    task automatic t_bit_clamp();
        bcfg_t a;
        a = '{mode: 0, tg: 5, gap: 3, pix: 6, rst: 1, clb: 2, smp: 1, extra: 1};
        run_lines(a, a, 2, 1'b0);
    endtask

    task automatic t_line_clamp();
        bcfg_t a;
        a = '{mode: 1, tg: 4, gap: 2, pix: 4, rst: 2, clb: 1, smp: 0, extra: 0};
        run_lines(a, a, 2, 1'b0);
    endtask

    task automatic t_reconfig();
        bcfg_t a, b;
        a = '{mode: 0, tg: 5, gap: 3, pix: 6, rst: 1, clb: 2, smp: 1, extra: 1};
        b = '{mode: 0, tg: 7, gap: 4, pix: 8, rst: 3, clb: 3, smp: 3, extra: 2};
        run_lines(a, b, 2, 1'b1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_bit_clamp();
        t_line_clamp();
        t_reconfig();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule